// File: doc/BRIEF.md
# Serial ADC Output Frame Generator

This block reproduces the digital output side of a 12-bit sampling converter that is read over a three-wire serial link (active-low select, serial clock, serial data). A falling select begins a frame and captures the two's-complement sample word. The serial clock is counted on its falling edges. The data driver switches on at the second fall and first sends a zero null bit. The word then follows MSB first, so B0 is sent on the fourteenth fall. If select is still low, the word is sent a second time LSB first, starting at B1 because B0 is not repeated. After B11 the driver lets go of the line.

The block runs on a fast system clock. Select and serial clock are level inputs that are already synchronous to that clock, and each serial-clock level must last at least one system clock. A serial-clock fall is recognised one system clock after it reaches the pin. The data and enable outputs change on the system-clock edge that recognises it. `ser_oe` stands for the tri-state enable of the data pad. When it is low, `ser_dout` is held at 0.

Top module: `adc_serial_tx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `ser_oe` and `ser_dout` are both 0.
- R2: A frame starts only when `cs_n` changes from 1 to 0. `sample_word` is captured on that transition, and later changes to `sample_word` during the frame do not alter the bits that are sent.
- R3: `ser_oe` stays 0 after the first falling serial-clock edge of a frame. After the second fall, `ser_oe` is 1 and `ser_dout` is 0 (the null bit).
- R4: After fall k, for k from 3 to 14, `ser_dout` carries word bit (14 - k). Fall 3 gives bit 11 and fall 14 gives bit 0.
- R5: `ser_dout` and `ser_oe` change only in the system-clock cycle that recognises a serial-clock fall, or when `cs_n` is high. While the serial clock is high or held low, they do not change.
- R6: With `cs_n` still low, fall k for k from 15 to 25 carries word bit (k - 14), so bit 0 is not sent again. After fall 26, `ser_oe` is 0.
- R7: Whenever `cs_n` is sampled high, `ser_oe` is 0 on the next system clock and the fall count is cleared. No repeat follows, and falls while `cs_n` is high drive nothing.
- R8: Falls after the end of a frame have no effect. The fall count saturates, so any number of extra falls leaves `ser_oe` at 0.
- R9: When `cs_n` rises in the same cycle that a fall is recognised, the rise wins and `ser_oe` goes to 0. When `cs_n` falls in the same cycle as a serial-clock fall, that fall is not counted.
- R10: If `cs_n` is already low when reset is released, no frame starts until `cs_n` has gone high and then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Frame select, active low, synchronous to clk |
| sclk | input | 1 | Serial clock level, synchronous to clk |
| sample_word | input | 12 | Two's-complement sample, registered upstream |
| ser_dout | output | 1 | Serial data bit, 0 while not driven |
| ser_oe | output | 1 | Data driver enable (high = driven) |

## Verification
A select rise and a serial-clock fall can both be recognised on one system-clock edge. At the fifteenth fall, this decides whether the LSB-first repeat starts or the line is released. The bench produces the overlap by driving `sclk` low and `cs_n` high in the same cycle, right after the fourteenth fall. It then expects `ser_oe` to be 0 one clock later. The mirrored case, a select fall in the same cycle as a serial-clock fall, is judged by requiring two further falls before the null bit appears.

// File: rtl/adcser_pkg.sv
// Shared definitions for the serial ADC output frame generator.
// Assumes: nothing beyond the standard language.
package adcser_pkg;
    // Which part of the frame a given fall count belongs to.
    typedef enum logic [2:0] {
        PH_IDLE,    // before the driver turns on
        PH_NULL,    // leading zero bit
        PH_MSB,     // word sent MSB first
        PH_LSB,     // word repeated LSB first
        PH_DONE     // frame over, line released
    } phase_e;
endpackage

// File: rtl/adcser_edge.sv
// Falling-edge detector for a level that is synchronous to clk.
// Assumes: the input is already synchronised and each level lasts >= 1 clk.
// RST_VAL is the assumed previous level after reset. With 0, a low level at
// reset release is not seen as a fall.
module adcser_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic lvl_q;

    // Keep the level seen on the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= RST_VAL;
        else        lvl_q <= lvl;
    end

    assign fall = lvl_q & ~lvl;
endmodule

// File: rtl/adcser_frame_cnt.sv
// Counts serial-clock falls inside one frame, saturating at MAX.
// Assumes: stop (select high) outranks start (select fall), and start
// outranks a tick that arrives in the same cycle.
module adcser_frame_cnt #(
    parameter int MAX = 26,
    localparam int CW = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic          active
);
    localparam logic [CW-1:0] CMAX = CW'(MAX);

    // Frame state: cleared by select high, armed by select fall, advanced by falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (stop) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (active && tick && cnt != CMAX) begin
            cnt    <= cnt + 1'b1;
        end
    end

    AST_HOLD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt == CMAX && !stop && !start) |=> (active && cnt == CMAX)); // R8
    AST_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> !active); // R10
endmodule

// File: rtl/adcser_bitsel.sv
// Maps the fall count and the captured word onto the serial data and enable.
// Assumes: cnt is 0 at frame start and counts falls; active is low outside a frame.
module adcser_bitsel
    import adcser_pkg::*;
#(
    parameter int W  = 12,
    localparam int CW = $clog2(2 * W + 3),
    localparam int IW = $clog2(W)
) (
    input  logic          active,
    input  logic [CW-1:0] cnt,
    input  logic [W-1:0]  word,
    output logic          dout,
    output logic          oe
);
    localparam int NULL_AT  = 2;
    localparam int MSB_LAST = W + 2;
    localparam int LSB_LAST = 2 * W + 1;

    phase_e          phase;
    logic [IW-1:0]   idx;

    // Classify the current count into a frame phase.
    always_comb begin
        if (!active || int'(cnt) < NULL_AT) phase = PH_IDLE;
        else if (int'(cnt) == NULL_AT)      phase = PH_NULL;
        else if (int'(cnt) <= MSB_LAST)     phase = PH_MSB;
        else if (int'(cnt) <= LSB_LAST)     phase = PH_LSB;
        else                                phase = PH_DONE;
    end

    // Pick the bit index and drive the enable for the phase.
    always_comb begin
        idx  = '0;
        oe   = 1'b0;
        dout = 1'b0;
        case (phase)
            PH_NULL: oe = 1'b1;
            PH_MSB: begin
                oe   = 1'b1;
                idx  = IW'(MSB_LAST - int'(cnt));
                dout = word[idx];
            end
            PH_LSB: begin
                oe   = 1'b1;
                idx  = IW'(int'(cnt) - MSB_LAST);
                dout = word[idx];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/adc_serial_tx.sv
// Top of the serial ADC output frame generator: edge detection on select and
// serial clock, word capture at frame start, fall counting and bit selection.
// Assumes: cs_n and sclk are synchronous to clk; sample_word is registered upstream.
module adc_serial_tx #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic [W-1:0] sample_word,
    output logic         ser_dout,
    output logic         ser_oe
);
    localparam int MAX = 2 * W + 2;
    localparam int CW  = $clog2(MAX + 1);

    logic          sclk_fall;
    logic          cs_fall;
    logic [CW-1:0] cnt;
    logic          active;
    logic [W-1:0]  word_q;

    adcser_edge #(.RST_VAL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sclk), .fall(sclk_fall)
    );

    adcser_edge #(.RST_VAL(1'b0)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .lvl(cs_n), .fall(cs_fall)
    );

    // Capture the sample word when a frame opens.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (cs_fall) word_q <= sample_word;
    end

    adcser_frame_cnt #(.MAX(MAX)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(cs_fall), .stop(cs_n),
        .tick(sclk_fall), .cnt(cnt), .active(active)
    );

    adcser_bitsel #(.W(W)) u_sel (
        .active(active), .cnt(cnt), .word(word_q),
        .dout(ser_dout), .oe(ser_oe)
    );

    AST_CS_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !ser_oe); // R7
    AST_NULL_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe) |-> !ser_dout); // R3
    AST_OE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe) |-> $past(sclk_fall)); // R5
    AST_BIT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && $past(ser_oe) && ser_dout != $past(ser_dout)) |-> $past(sclk_fall)); // R5
endmodule

// File: tb/test_adc_serial_tx.sv
// Directed bench for adc_serial_tx: one task per scenario, each checking itself.
module test_adc_serial_tx;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b0;
    logic         sclk = 1'b1;
    logic [W-1:0] sample_word = '0;
    logic         ser_dout;
    logic         ser_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adc_serial_tx #(.W(W)) i_adc_serial_tx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sample_word(sample_word), .ser_dout(ser_dout), .ser_oe(ser_oe)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_oe(input int k);
        return (k >= 2 && k <= 2 * W + 1);
    endfunction

    function automatic logic exp_bit(input int k, input logic [W-1:0] w);
        if (k >= 3 && k <= W + 2)          return w[W + 2 - k];
        else if (k > W + 2 && k <= 2*W+1)  return w[k - (W + 2)];
        else                               return 1'b0;
    endfunction

    task automatic sclk_up();
        @(negedge clk) sclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic sclk_down();
        @(negedge clk) sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic open_frame(input logic [W-1:0] w);
        @(negedge clk) begin cs_n = 1'b1; sclk = 1'b1; end
        @(negedge clk) begin cs_n = 1'b0; sample_word = w; end
        @(negedge clk);
    endtask

    task automatic close_frame();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
    endtask

    // Reset values, and a select held low across reset release.
    task automatic t_reset();
        rst_n = 1'b0; cs_n = 1'b0; sclk = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", W'(ser_oe), '0);
        chk("R1 dout in reset", W'(ser_dout), '0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after reset", W'(ser_oe), '0);
        for (int k = 1; k <= 4; k++) begin
            sclk_up(); sclk_down();
            chk("R10 no frame without select edge", W'(ser_oe), '0);
        end
    endtask

    // Whole frame with repeat, word changed after capture, then extra falls.
    task automatic t_full(input logic [W-1:0] w);
        logic prev_oe, prev_dout;
        open_frame(w);
        sample_word = ~w;
        prev_oe = 1'b0; prev_dout = 1'b0;
        for (int k = 1; k <= 2 * W + 2; k++) begin
            sclk_up();
            chk("R5 oe steady while sclk high", W'(ser_oe), W'(prev_oe));
            chk("R5 dout steady while sclk high", W'(ser_dout), W'(prev_dout));
            sclk_down();
            if (k <= 2)            chk("R3 enable timing", W'(ser_oe), W'(exp_oe(k)));
            else if (k <= W + 2)   chk("R4 msb-first bit", W'(ser_dout), W'(exp_bit(k, w)));
            else                   chk("R6 lsb-first repeat", W'({ser_oe, ser_dout}),
                                       W'({exp_oe(k), exp_bit(k, w)}));
            if (k == 2) chk("R3 null bit", W'(ser_dout), '0);
            if (k == 3) chk("R2 captured word msb", W'(ser_dout), W'(w[W-1]));
            repeat (2) @(negedge clk);
            chk("R5 steady while sclk low", W'({ser_oe, ser_dout}), W'({exp_oe(k), exp_bit(k, w)}));
            prev_oe = ser_oe; prev_dout = ser_dout;
        end
        for (int k = 0; k < 40; k++) begin
            sclk_up(); sclk_down();
            if (ser_oe !== 1'b0) chk("R8 extra falls ignored", W'(ser_oe), '0);
        end
        chk("R8 still released after 40 extra falls", W'(ser_oe), '0);
        close_frame();
    endtask

    // Select raised right after B0: line released, nothing more sent.
    task automatic t_early(input logic [W-1:0] w);
        open_frame(w);
        for (int k = 1; k <= W + 2; k++) begin sclk_up(); sclk_down(); end
        chk("R4 b0 at fall 14", W'(ser_dout), W'(w[0]));
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        chk("R7 select high releases line", W'(ser_oe), '0);
        for (int k = 0; k < 5; k++) begin
            sclk_up(); sclk_down();
            chk("R7 no repeat while select high", W'(ser_oe), '0);
        end
    endtask

    // Select rise in the same cycle as the 15th fall.
    task automatic t_tie_rise(input logic [W-1:0] w);
        open_frame(w);
        for (int k = 1; k <= W + 2; k++) begin sclk_up(); sclk_down(); end
        chk("R9 driving before tie", W'(ser_oe), 1);
        sclk_up();
        @(negedge clk) begin sclk = 1'b0; cs_n = 1'b1; end
        @(negedge clk);
        chk("R9 rise beats fall", W'(ser_oe), '0);
        chk("R9 dout idle", W'(ser_dout), '0);
    endtask

    // Select fall in the same cycle as a serial-clock fall: not counted.
    task automatic t_tie_fall(input logic [W-1:0] w);
        @(negedge clk) begin cs_n = 1'b1; sclk = 1'b1; end
        @(negedge clk) begin cs_n = 1'b0; sclk = 1'b0; sample_word = w; end
        @(negedge clk);
        chk("R9 coincident fall oe", W'(ser_oe), '0);
        sclk_up(); sclk_down();
        chk("R9 first counted fall oe", W'(ser_oe), '0);
        sclk_up(); sclk_down();
        chk("R3 null after second counted fall", W'({ser_oe, ser_dout}), W'(2'b10));
        sclk_up(); sclk_down();
        chk("R4 msb after tie", W'(ser_dout), W'(w[W-1]));
        close_frame();
    endtask

    initial begin
        t_reset();
        t_full(12'hA5C);
        t_full(12'h800);
        t_full(12'h7FF);
        t_early(12'h001);
        t_tie_rise(12'h3C6);
        t_tie_fall(12'hFFF);
        t_full(12'h359);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule